// File: doc/BRIEF.md
# Iterative Multiply and Divide Unit

This block does the slow integer arithmetic for the execute stage of a pipelined processor. It works on two 32-bit operands. It forms the full 64-bit signed product with a radix-2 Booth recurrence, or the unsigned quotient and remainder with a restoring shift-and-subtract recurrence. It does one step per clock, and one control counter drives both recurrences. Both operations load the same pair of result registers, `hi` and `lo`.

The pipeline pulses `go` for one cycle, with `op_div` and both operands valid in that cycle. `busy` then stays high while the unit iterates. The result registers change in the same cycle that `busy` falls. Only one operation runs at a time. A `go` pulse that arrives during a run is dropped. Stalling dependent instructions and moving `hi` and `lo` into the register file are handled by logic outside this block.

Top module: `mdu_iter`

## Requirements
- R1: After a synchronous reset, `busy`, `hi` and `lo` are all zero.
- R2: A `go` pulse sampled while `busy` is low makes `busy` high in the next cycle.
- R3: Once raised, `busy` stays high for exactly 32 cycles. It falls in the same cycle that `hi` and `lo` take the result.
- R4: With `op_div` = 0, the operands are read as two's-complement numbers. `hi` receives bits 63..32 and `lo` receives bits 31..0 of the signed product `opnd_a * opnd_b`.
- R5: With `op_div` = 1, the operands are read as unsigned numbers. `lo` receives `opnd_a / opnd_b` and `hi` receives `opnd_a % opnd_b`.
- R6: A divide with `opnd_b` = 0 raises no error. `lo` receives 0xFFFFFFFF and `hi` receives `opnd_a` unchanged.
- R7: A `go` pulse sampled while `busy` is high is ignored. The run in progress keeps its length and its result, and the ignored request produces no result later.
- R8: `hi` and `lo` hold their values at all times except the completion cycle of a run, both while `busy` is high and while the unit is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | One-cycle request to start an operation |
| op_div | input | 1 | 0 = signed multiply, 1 = unsigned divide |
| opnd_a | input | 32 | Multiplicand, or dividend |
| opnd_b | input | 32 | Multiplier, or divisor |
| busy | output | 1 | High while an operation is in flight |
| hi | output | 32 | Upper product half, or remainder |
| lo | output | 32 | Lower product half, or quotient |

## Verification
The bench crosses the operands 0x80000000, 0xFFFFFFFF, 0 and 1 in both operations, and adds seeded pseudo-random pairs. Two corner cases stand out:
- Multiplying by 0x80000000: a Booth accumulator with no guard bit overflows when it subtracts the most negative multiplicand, which gives a product with the wrong sign.
- Dividing 0xFFFFFFFF or 0x80000000: a divider that treats its operands as signed returns a negative quotient.

Dividing by zero checks that the restoring recurrence itself gives an all-ones quotient and keeps the dividend as the remainder, with no special-case logic. The bench counts `busy` cycles on every run to catch an off-by-one in the step counter. It also sends a second request in the middle of a run; a unit that accepted it would restart its count or load the second request's result.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic {
    MDU_MUL = 1'b0,
    MDU_DIV = 1'b1
  } mdu_op_e;
endpackage

// File: rtl/mdu_seq.sv
module mdu_seq #(
  parameter int ITER = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic busy,
  output logic accept,
  output logic last
);
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(ITER - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign busy   = busy_q;
  assign accept = go && !busy_q;
  assign last   = busy_q && (cnt_q == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  start_raises_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (go && !busy) |=> busy);

  // R3
  last_drops_busy_chk: assert property (@(posedge clk) disable iff (rst)
    last |=> !busy);

  // R7
  go_while_busy_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (go && busy && !last) |=> (busy && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/mdu_booth_step.sv
module mdu_booth_step #(
  parameter int W = 32
) (
  input  logic [W:0]   acc_i,
  input  logic [W-1:0] mplr_i,
  input  logic         prev_i,
  input  logic [W-1:0] mcand,
  output logic [W:0]   acc_o,
  output logic [W-1:0] mplr_o,
  output logic         prev_o
);
  logic [W:0] mc_ext;
  logic [W:0] sum;

  assign mc_ext = {mcand[W-1], mcand};

  always_comb begin
    unique case ({mplr_i[0], prev_i})
      2'b01:   sum = acc_i + mc_ext;
      2'b10:   sum = acc_i - mc_ext;
      default: sum = acc_i;
    endcase
    {acc_o, mplr_o, prev_o} = {sum[W], sum, mplr_i};
  end
endmodule

// File: rtl/mdu_restore_step.sv
module mdu_restore_step #(
  parameter int W = 32
) (
  input  logic [W:0]   rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvsr,
  output logic [W:0]   rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0] shifted;
  logic [W:0] diff;
  logic       neg;

  assign shifted = {rem_i[W-1:0], quo_i[W-1]};
  assign diff    = shifted - {1'b0, dvsr};
  assign neg     = diff[W];
  assign rem_o   = neg ? shifted : diff;
  assign quo_o   = {quo_i[W-2:0], ~neg};
endmodule

// File: rtl/mdu_iter.sv
module mdu_iter
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic         op_div,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         busy,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int ITER = W;

  logic accept, last;

  mdu_seq #(.ITER(ITER)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .go     (go),
    .busy   (busy),
    .accept (accept),
    .last   (last)
  );

  mdu_op_e     op_q;
  logic [W:0]  acc_q;
  logic [W-1:0] sh_q;
  logic [W-1:0] opnd_q;
  logic        prev_q;
  logic [W-1:0] hi_q, lo_q;

  logic [W:0]   b_acc, d_rem;
  logic [W-1:0] b_sh, d_sh;
  logic         b_prev;

  mdu_booth_step #(.W(W)) u_booth (
    .acc_i  (acc_q),
    .mplr_i (sh_q),
    .prev_i (prev_q),
    .mcand  (opnd_q),
    .acc_o  (b_acc),
    .mplr_o (b_sh),
    .prev_o (b_prev)
  );

  mdu_restore_step #(.W(W)) u_div (
    .rem_i (acc_q),
    .quo_i (sh_q),
    .dvsr  (opnd_q),
    .rem_o (d_rem),
    .quo_o (d_sh)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= MDU_MUL;
      acc_q  <= '0;
      sh_q   <= '0;
      opnd_q <= '0;
      prev_q <= 1'b0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (accept) begin
      op_q   <= mdu_op_e'(op_div);
      acc_q  <= '0;
      prev_q <= 1'b0;
      sh_q   <= op_div ? opnd_a : opnd_b;
      opnd_q <= op_div ? opnd_b : opnd_a;
    end else if (busy) begin
      if (op_q == MDU_DIV) begin
        acc_q <= d_rem;
        sh_q  <= d_sh;
      end else begin
        acc_q  <= b_acc;
        sh_q   <= b_sh;
        prev_q <= b_prev;
      end
      if (last) begin
        hi_q <= (op_q == MDU_DIV) ? d_rem[W-1:0] : b_acc[W-1:0];
        lo_q <= (op_q == MDU_DIV) ? d_sh : b_sh;
      end
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!busy && hi == '0 && lo == '0));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !last |=> ($stable(hi) && $stable(lo)));

  // R5
  remainder_below_divisor_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && op_q == MDU_DIV && opnd_q != '0) |-> (acc_q < {1'b0, opnd_q}));

  // R6
  div_zero_all_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (last && op_q == MDU_DIV && opnd_q == '0) |=> (lo == '1));
endmodule

// File: tb/mdu_iter_test.sv
module mdu_iter_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        go;
  logic        op_div;
  logic [31:0] opnd_a, opnd_b;
  logic        busy;
  logic [31:0] hi, lo;

  int vectors = 0;
  int errors  = 0;

  always #2 clk = ~clk;

  mdu_iter #(.W(32)) uut (
    .clk(clk), .rst(rst), .go(go), .op_div(op_div),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .busy(busy), .hi(hi), .lo(lo)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_result(input logic d, input logic [31:0] a, input logic [31:0] b,
                               output logic [31:0] eh, output logic [31:0] el);
    longint sa, sb, p;
    if (d) begin
      if (b == 0) begin el = 32'hFFFF_FFFF; eh = a; end
      else begin el = a / b; eh = a % b; end
    end else begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      p  = sa * sb;
      eh = p[63:32];
      el = p[31:0];
    end
  endtask

  // Start one operation, optionally inject a second request mid-run.
  task automatic run_op(input logic d, input logic [31:0] a, input logic [31:0] b,
                        input bit intrude, input string name);
    logic [31:0] eh, el, h0, l0;
    int n;
    bit held;
    expect_result(d, a, b, eh, el);
    @(negedge clk);
    h0 = hi; l0 = lo;
    go = 1'b1; op_div = d; opnd_a = a; opnd_b = b;
    @(negedge clk);
    go = 1'b0; opnd_a = ~a; opnd_b = b ^ 32'h5A5A_0001; op_div = ~d;
    chk({"R2 busy after go ", name}, {63'd0, busy}, 64'd1);
    n = 1; held = 1'b1;
    while (busy && n < 100) begin
      if (intrude && n == 10) go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      if (busy) begin
        n++;
        if (hi !== h0 || lo !== l0) held = 1'b0;
      end
    end
    chk({"R3 busy length ", name}, 64'(n), 64'd32);
    chk({"R8 hold while busy ", name}, {63'd0, held}, 64'd1);
    if (intrude) chk({"R7 ignored go result ", name}, {hi, lo}, {eh, el});
    else if (d) begin
      if (b == 0) chk({"R6 div by zero ", name}, {hi, lo}, {eh, el});
      else        chk({"R5 divide ", name}, {hi, lo}, {eh, el});
    end else      chk({"R4 multiply ", name}, {hi, lo}, {eh, el});
  endtask

  task automatic t_reset;
    rst = 1'b1; go = 1'b0; op_div = 1'b0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset busy", {63'd0, busy}, 64'd0);
    chk("R1 reset hi/lo", {hi, lo}, 64'd0);
  endtask

  task automatic t_corners;
    logic [31:0] cv [4];
    cv[0] = 32'h8000_0000; cv[1] = 32'hFFFF_FFFF; cv[2] = 32'h0; cv[3] = 32'h1;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        run_op(1'b0, cv[i], cv[j], 1'b0, "R4 corner");
        run_op(1'b1, cv[i], cv[j], 1'b0, "R5 corner");
      end
  endtask

  task automatic t_random;
    logic [31:0] a, b;
    for (int k = 0; k < 40; k++) begin
      a = $urandom; b = $urandom;
      if (k % 4 == 1) b = b >> (b[4:0]);
      run_op(1'b0, a, b, 1'b0, "R4 random");
      run_op(1'b1, a, b, 1'b0, "R5 random");
    end
  endtask

  task automatic t_div_zero;
    run_op(1'b1, 32'h1234_5678, 32'h0, 1'b0, "R6 zero");
    run_op(1'b1, 32'hDEAD_BEEF, 32'h0, 1'b0, "R6 zero");
  endtask

  task automatic t_intrude;
    run_op(1'b0, 32'hFFFF_FFF9, 32'h0000_0123, 1'b1, "R7 mul");
    run_op(1'b1, 32'h0098_7654, 32'h0000_0033, 1'b1, "R7 div");
  endtask

  task automatic t_idle_hold;
    logic [31:0] h0, l0;
    run_op(1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, "R4 max");
    h0 = hi; l0 = lo;
    opnd_a = 32'h1; opnd_b = 32'h2; op_div = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8 idle hold", {hi, lo}, {h0, l0});
    chk("R8 idle busy low", {63'd0, busy}, 64'd0);
  endtask

  initial begin
    void'($urandom(32'd1357));
    t_reset();
    t_corners();
    t_random();
    t_div_zero();
    t_intrude();
    t_idle_hold();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule